// File: doc/BRIEF.md
# Multichannel SAR conversion sequencer

This block is the digital controller of a successive-approximation converter that has an eight-way analog input multiplexer. A convert-start pulse puts the input into hold. The block then runs a binary search, one result bit per clock from the most significant bit down. In each search cycle it drives a trial code to an external DAC and samples the comparator's verdict. When the least significant bit is decided, it presents the result together with the channel number it belongs to. The result comes with no pipeline delay.

The sequencer can pick its channel in two ways. It can use one directly addressed channel, or it can walk through the channels marked in an enable mask in ascending index order. The run length is set by a mode. Single-shot does one conversion. Burst does one pass through the mask. Continuous loops over the mask until a stop request arrives. The internal bit clock is free-running; convert-start may arrive at any cycle of it.

Top module: `sar_seq_ctrl`

## Requirements
- R1: The first trial code of every conversion is midscale: only the MSB of `dac_code_o` is set when `hold_o` rises.
- R2: Each cycle decides one bit. The trial bit is kept at 1 when `cmp_i` is 1 (held input at or above the DAC code) and cleared otherwise, and the next lower bit is set. The next trial is therefore above the previous one after a 1 and below it after a 0, and a conversion lasts exactly RES_BITS cycles.
- R3: With an ideal comparator, the result is the largest code not above the held input. For example, an input of 45 on a 6-bit scale, scaled to 12 bits (0xB40), gives 0xB40. Zero gives 0 and full scale gives all ones.
- R4: `done_o` pulses high for one cycle when the result is loaded. In that same cycle `result_o` holds the value and `result_ch_o` holds the 3-bit channel number of the conversion just finished. `hold_o` is low while `done_o` is high.
- R5: `hold_o` is high exactly during search cycles. The selected channel is stable while it is high, and `hold_o` is low for at least one cycle between consecutive conversions.
- R6: `busy_o` rises the cycle after an accepted start. It falls in the cycle the last result of the run is presented.
- R7: A start pulse while `busy_o` is high is ignored. It produces no extra conversion.
- R8: With `seq_en_i` = 0, the channel converted is `ch_addr_i`.
- R9: With `seq_en_i` = 1, channels whose bit is set in `ch_mask_i` (bit i = channel i) are converted in ascending order, starting from the lowest enabled one. In single-shot mode only that lowest channel is converted.
- R10: Mode 2'b01 (burst) converts each enabled channel once and then returns to idle.
- R11: Mode 2'b10 (continuous) wraps from the highest enabled channel back to the lowest. A pulse on `stop_i` lets the running conversion finish and then ends the run. Mode 2'b00 (and 2'b11) is single-shot.
- R12: A start with `seq_en_i` = 1 and an all-zero mask is ignored, and the block stays idle.
- R13: After reset, `busy_o`, `hold_o` and `done_o` are low and `dac_code_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-decision clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Convert-start pulse |
| stop_i | input | 1 | Ends a continuous run after the current conversion |
| mode_i | input | 2 | 00 single-shot, 01 burst, 10 continuous, 11 single-shot |
| seq_en_i | input | 1 | 1 = walk the mask, 0 = addressed channel |
| ch_mask_i | input | NUM_CH | Channel enable mask, bit i = channel i |
| ch_addr_i | input | 3 | Addressed channel |
| cmp_i | input | 1 | Comparator: 1 when held input >= DAC code |
| dac_code_o | output | RES_BITS | Trial code to the DAC, zero outside conversions |
| hold_o | output | 1 | Track/hold control, 1 = hold |
| mux_sel_o | output | 3 | Multiplexer channel select |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | RES_BITS | Conversion result |
| result_ch_o | output | 3 | Channel number of the result |

## Verification
The assertions assume the comparator answers within the same cycle for the code on `dac_code_o`. They also assume the held input does not change while `hold_o` is high, because the direction check on successive trials depends on it. The bench models the comparator as a combinational compare between a fixed per-channel value, at a finer scale than the code, and the current trial code. It changes the channel values only while the block is idle. Mode, mask and address are set before each start and held for the whole run.

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int RES_BITS = 12,
  parameter int NUM_CH   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [1:0]           mode_i,
  input  logic                 seq_en_i,
  input  logic [NUM_CH-1:0]    ch_mask_i,
  input  logic [$clog2(NUM_CH)-1:0] ch_addr_i,
  input  logic                 cmp_i,
  output logic [RES_BITS-1:0]  dac_code_o,
  output logic                 hold_o,
  output logic [$clog2(NUM_CH)-1:0] mux_sel_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [RES_BITS-1:0]  result_o,
  output logic [$clog2(NUM_CH)-1:0] result_ch_o
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam logic [1:0] M_BURST = 2'b01;
  localparam logic [1:0] M_CONT  = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_ACQ} st_t;

  st_t                st;
  logic [RES_BITS-1:0] trial, probe;
  logic [CH_W-1:0]    cur_ch;
  logic [1:0]         mode_r;
  logic               seq_r, stop_req;
  logic [NUM_CH-1:0]  mask_r;

  logic [CH_W-1:0] lo_in, lo_r, nxt;
  logic            has_nxt, go, cont;
  logic [RES_BITS-1:0] decided;

  always_comb begin
    lo_in = '0;
    lo_r  = '0;
    nxt   = '0;
    has_nxt = 1'b0;
    for (int i = NUM_CH-1; i >= 0; i--) begin
      if (ch_mask_i[i]) lo_in = CH_W'(i);
      if (mask_r[i]) lo_r = CH_W'(i);
      if (mask_r[i] && i > int'(cur_ch)) begin
        nxt = CH_W'(i);
        has_nxt = 1'b1;
      end
    end
  end

  assign decided = cmp_i ? trial : (trial & ~probe);
  assign go   = start_i && (!seq_en_i || (|ch_mask_i));
  assign cont = !(stop_req || stop_i) &&
                ((mode_r == M_CONT) || (mode_r == M_BURST && seq_r && has_nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      trial <= '0;
      probe <= '0;
      cur_ch <= '0;
      mode_r <= '0;
      seq_r <= 1'b0;
      stop_req <= 1'b0;
      mask_r <= '0;
      done_o <= 1'b0;
      result_o <= '0;
      result_ch_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st <= S_CONV;
          mode_r <= mode_i;
          seq_r <= seq_en_i;
          mask_r <= ch_mask_i;
          cur_ch <= seq_en_i ? lo_in : ch_addr_i;
          trial <= MID;
          probe <= MID;
          stop_req <= 1'b0;
        end
        S_CONV: begin
          stop_req <= stop_req | stop_i;
          probe <= probe >> 1;
          trial <= decided | (probe >> 1);
          if (probe[0]) begin
            result_o <= decided;
            result_ch_o <= cur_ch;
            done_o <= 1'b1;
            if (cont) begin
              st <= S_ACQ;
              if (seq_r) cur_ch <= has_nxt ? nxt : lo_r;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_ACQ: begin
          stop_req <= stop_req | stop_i;
          st <= S_CONV;
          trial <= MID;
          probe <= MID;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dac_code_o = (st == S_CONV) ? trial : '0;
  assign hold_o     = (st == S_CONV);
  assign busy_o     = (st != S_IDLE);
  assign mux_sel_o  = cur_ch;

  a_r1_midscale_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> dac_code_o == MID);

  a_r2_trial_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o)) |->
      ($past(cmp_i) ? (dac_code_o > $past(dac_code_o)) : (dac_code_o < $past(dac_code_o))));

  a_r4_done_out_of_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !hold_o);

  a_r5_channel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_o && $past(hold_o)) |-> $stable(mux_sel_o));

  a_r5_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> busy_o);

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r6_busy_falls_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/sim_sar_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sar_seq_ctrl;
  localparam int RES = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, seq_en_i = 0, cmp_i;
  logic [1:0] mode_i = 0;
  logic [7:0] ch_mask_i = 0;
  logic [2:0] ch_addr_i = 0;
  logic [RES-1:0] dac_code_o, result_o;
  logic hold_o, busy_o, done_o;
  logic [2:0] mux_sel_o, result_ch_o;
  int vinf [8];
  int errors = 0, checks = 0, cyc = 0;

  always #4 clk = ~clk;

  sar_seq_ctrl #(.RES_BITS(RES), .NUM_CH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .mode_i(mode_i),
    .seq_en_i(seq_en_i), .ch_mask_i(ch_mask_i), .ch_addr_i(ch_addr_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .hold_o(hold_o), .mux_sel_o(mux_sel_o), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .result_ch_o(result_ch_o));

  assign cmp_i = vinf[mux_sel_o] >= int'(dac_code_o) * 4;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(output bit found);
    found = 1'b0;
    for (int n = 0; n < 4*RES && !found; n++) begin
      @(negedge clk);
      if (done_o) found = 1'b1;
    end
  endtask

  task automatic t_reset();
    chk(!busy_o && !hold_o && !done_o && dac_code_o == 0, "R13 reset outputs", int'(busy_o), 0);
  endtask

  task automatic t_single_addr(input int ch, input int v);
    int expv;
    expv = v / 4;
    vinf[ch] = v;
    mode_i = 2'b00; seq_en_i = 1'b0; ch_addr_i = 3'(ch);
    pulse_start();
    chk(busy_o == 1'b1, "R6 busy after start", int'(busy_o), 1);
    for (int k = RES-1; k >= 0; k--) begin
      int mk, tr;
      mk = (1 << (k+1)) - 1;
      tr = (expv & ~mk) | (1 << k);
      if (k == RES-1) chk(int'(dac_code_o) == tr, "R1 midscale first trial", int'(dac_code_o), tr);
      else chk(int'(dac_code_o) == tr, "R2 trial sequence", int'(dac_code_o), tr);
      chk(hold_o == 1'b1, "R5 hold during search", int'(hold_o), 1);
      @(negedge clk);
    end
    chk(done_o == 1'b1, "R2 done after RES cycles", int'(done_o), 1);
    chk(int'(result_o) == expv, "R3 result value", int'(result_o), expv);
    chk(int'(result_ch_o) == ch, "R8 addressed channel", int'(result_ch_o), ch);
    chk(busy_o == 1'b0 && hold_o == 1'b0, "R6 busy falls with result", int'(busy_o), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R4 done is one pulse", int'(done_o), 0);
  endtask

  task automatic t_ignore();
    bit f;
    int extra;
    vinf[3] = 1000;
    mode_i = 2'b00; seq_en_i = 1'b0; ch_addr_i = 3'd3;
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_done(f);
    chk(f, "R7 first conversion completes", int'(f), 1);
    chk(int'(result_o) == 250, "R7 result", int'(result_o), 250);
    extra = 0;
    repeat (2*RES) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    chk(extra == 0, "R7 start while busy ignored", extra, 0);
  endtask

  task automatic t_burst();
    bit f;
    int exp_ch [3] = '{1, 3, 6};
    int stray;
    vinf[1] = 400; vinf[3] = 8000; vinf[6] = 16000;
    mode_i = 2'b01; seq_en_i = 1'b1; ch_mask_i = 8'h4A;
    pulse_start();
    for (int i = 0; i < 3; i++) begin
      wait_done(f);
      chk(f && int'(result_ch_o) == exp_ch[i], "R9 burst channel order", int'(result_ch_o), exp_ch[i]);
      chk(int'(result_o) == vinf[exp_ch[i]] / 4, "R3 burst result", int'(result_o), vinf[exp_ch[i]] / 4);
      chk(busy_o == (i < 2), "R10 busy through pass only", int'(busy_o), int'(i < 2));
    end
    stray = 0;
    repeat (RES+4) begin
      @(negedge clk);
      if (done_o) stray++;
    end
    chk(stray == 0, "R10 burst stops after one pass", stray, 0);
  endtask

  task automatic t_single_seq();
    bit f;
    vinf[4] = 16383;
    mode_i = 2'b00; seq_en_i = 1'b1; ch_mask_i = 8'h30;
    pulse_start();
    wait_done(f);
    chk(f && int'(result_ch_o) == 4, "R9 single-shot lowest enabled", int'(result_ch_o), 4);
    chk(int'(result_o) == 4095, "R3 full scale", int'(result_o), 4095);
    chk(busy_o == 1'b0, "R9 single-shot ends", int'(busy_o), 0);
  endtask

  task automatic t_cont();
    bit f;
    int exp_ch [6] = '{2, 5, 7, 2, 5, 7};
    vinf[2] = 5; vinf[5] = 9999; vinf[7] = 2047;
    mode_i = 2'b10; seq_en_i = 1'b1; ch_mask_i = 8'hA4;
    pulse_start();
    for (int i = 0; i < 6; i++) begin
      wait_done(f);
      chk(f && int'(result_ch_o) == exp_ch[i], "R11 continuous wrap order", int'(result_ch_o), exp_ch[i]);
      chk(hold_o == 1'b0, "R5 track gap between conversions", int'(hold_o), 0);
      chk(busy_o == (i < 5), "R11 stop ends after current", int'(busy_o), int'(i < 5));
      if (i == 4) begin
        stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
      end
    end
    chk(int'(result_o) == 511, "R3 continuous result", int'(result_o), 511);
  endtask

  task automatic t_empty_mask();
    int act;
    mode_i = 2'b00; seq_en_i = 1'b1; ch_mask_i = 8'h00;
    pulse_start();
    act = 0;
    repeat (RES+2) begin
      @(negedge clk);
      if (busy_o || hold_o || done_o) act++;
    end
    chk(act == 0, "R12 empty mask ignored", act, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (vinf[i]) vinf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_addr(6, 11520);
    t_single_addr(0, 0);
    t_single_addr(2, 16383);
    t_single_addr(5, 1234*4 + 3);
    t_ignore();
    t_burst();
    t_single_seq();
    t_cont();
    t_empty_mask();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule